// File: doc/BRIEF.md
# Sorting-Network Majority Voter

This block takes a vector of single-bit check sums and decides whether more than half of them are set. Rather than counting ones and comparing the count with a threshold, it passes the bits through a fixed network of two-input comparators. Each comparator is one AND gate, which gives the minimum, and one OR gate, which gives the maximum. The schedule of comparisons is set when the design is elaborated and never depends on the data, so every input vector takes the same path through the same gates.

The network is an odd-even transposition sorter with K stages. When it finishes, every one has moved to the high-index end and every zero to the low-index end. The vote is read from a single sorted position: the (floor(K/2)+1)-th wire counted from the high end. That wire is 1 exactly when the input holds more ones than zeros, so a tie with an even K gives 0. The sorted vector and the vote are registered together by default, with a synchronous active-high reset. A parameter can remove that register for a purely combinational voter.

Top module: `sortvote_majority`

## Requirements
- R1: With the default registered output, `vote` after a rising edge is 1 exactly when the `sums` sampled at that edge held more than K/2 ones, and is 0 otherwise.
- R2: For an even K, an input with exactly K/2 ones (a tie) gives `vote` = 0.
- R3: The number of ones on `sorted` equals the number of ones on the `sums` sampled at the previous edge.
- R4: `sorted` is a thermometer code: with c ones at the input, bits K-1 down to K-c are 1 and bits K-c-1 down to 0 are 0.
- R5: An all-zero input gives `vote` = 0 and `sorted` = 0. An all-one input gives `vote` = 1 and `sorted` all ones.
- R6: While `rst` is high at a rising edge, `sorted` and `vote` become 0 after that edge, whatever `sums` holds.
- R7: Each result depends only on the vector sampled at its own edge. A new vector on every cycle gives a correct result on every cycle, and earlier vectors leave no trace.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sums | input | K | Check-sum bits to be voted on |
| sorted | output | K | Sorted copy of the input, ones at the high indices (registered) |
| vote | output | 1 | Majority decision, 1 when ones outnumber zeros (registered) |

## Verification
The hard cases are the ones that sit right at the decision boundary. A tie, and the vectors with one more or one fewer one than half, are where a tap taken from the wrong sorted position or a missing comparator shows up. Other vectors can hide such faults. The bench therefore drives all 2^K input vectors back to back, one per cycle, so that every boundary count arrives with every arrangement of its ones. It adds alternating all-zero and all-one vectors, to prove that no result depends on the one before it, and a reset asserted while a high vote is held.

// File: rtl/sortvote_pkg.sv
package sortvote_pkg;
  // Index of the sorted wire that carries the vote: the (floor(k/2)+1)-th
  // wire counted from the high (maximum) end of the network.
  function automatic int unsigned vote_tap(input int unsigned k);
    return k - 1 - (k / 2);
  endfunction
endpackage

// File: rtl/sortvote_cmp.sv
module sortvote_cmp (
  input  logic a,
  input  logic b,
  output logic lo,
  output logic hi
);
  assign lo = a & b;
  assign hi = a | b;
endmodule

// File: rtl/sortvote_net.sv
module sortvote_net #(
  parameter int unsigned K = 8
) (
  input  logic [K-1:0] din,
  output logic [K-1:0] dout
);
  localparam int unsigned STAGES = K;

  logic [K-1:0] lane [0:STAGES];

  assign lane[0] = din;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    localparam int unsigned PAR = s % 2;
    for (genvar i = 0; i < K; i++) begin : g_wire
      if (((i % 2) == PAR) && (i + 1 < K)) begin : g_cmp
        sortvote_cmp u_cmp (
          .a  (lane[s][i]),
          .b  (lane[s][i+1]),
          .lo (lane[s+1][i]),
          .hi (lane[s+1][i+1])
        );
      end else if (!((i > 0) && (((i - 1) % 2) == PAR))) begin : g_pass
        assign lane[s+1][i] = lane[s][i];
      end
    end
  end

  assign dout = lane[STAGES];
endmodule

// File: rtl/sortvote_reg.sv
module sortvote_reg #(
  parameter int unsigned W   = 9,
  parameter bit          REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  if (REG) begin : g_ff
    always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= d;
    end
  end else begin : g_wire
    assign q = d;
  end
endmodule

// File: rtl/sortvote_majority.sv
module sortvote_majority #(
  parameter int unsigned K       = 8,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [K-1:0] sums,
  output logic [K-1:0] sorted,
  output logic         vote
);
  import sortvote_pkg::*;

  localparam int unsigned TAP = vote_tap(K);
  localparam int unsigned W   = K + 1;

  logic [K-1:0] net_out;
  logic [W-1:0] stage_d;
  logic [W-1:0] stage_q;

  sortvote_net #(.K(K)) u_net (
    .din  (sums),
    .dout (net_out)
  );

  assign stage_d = {net_out[TAP], net_out};

  sortvote_reg #(.W(W), .REG(REG_OUT)) u_out (
    .clk (clk),
    .rst (rst),
    .d   (stage_d),
    .q   (stage_q)
  );

  assign sorted = stage_q[K-1:0];
  assign vote   = stage_q[K];
endmodule

// File: rtl/sortvote_chk.sv
module sortvote_chk #(
  parameter int unsigned K       = 8,
  parameter bit          REG_OUT = 1'b1
) (
  input logic         clk,
  input logic         rst,
  input logic [K-1:0] sums,
  input logic [K-1:0] sorted,
  input logic         vote
);
  logic primed;

  always_ff @(posedge clk) begin
    if (rst) primed <= 1'b0;
    else     primed <= 1'b1;
  end

  // R4: a one at any index implies ones at every higher index
  assert_thermometer_R4: assert property (@(posedge clk) disable iff (rst)
    ((sorted & ~{1'b1, sorted[K-1:1]}) == '0));

  if (REG_OUT) begin : g_reg
    assert_ones_kept_R3: assert property (@(posedge clk) disable iff (rst)
      primed |-> ($countones(sorted) == $past($countones(sums))));

    assert_majority_R1: assert property (@(posedge clk) disable iff (rst)
      primed |-> (vote == ($past($countones(sums)) > (K / 2))));

    assert_reset_clear_R6: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> ((sorted == '0) && !vote));
  end else begin : g_comb
    assert_ones_kept_R3: assert property (@(posedge clk) disable iff (rst)
      primed |-> ($countones(sorted) == $countones(sums)));

    assert_majority_R1: assert property (@(posedge clk) disable iff (rst)
      primed |-> (vote == ($countones(sums) > (K / 2))));
  end
endmodule

bind sortvote_majority sortvote_chk #(.K(K), .REG_OUT(REG_OUT)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .sums   (sums),
  .sorted (sorted),
  .vote   (vote)
);

// File: tb/sortvote_majority_test.sv
module sortvote_majority_test;
  localparam int unsigned K = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [K-1:0] sums = '0;
  logic [K-1:0] sorted;
  logic         vote;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct packed {
    logic [K-1:0] vec;
    logic [K-1:0] exp_sorted;
    logic         exp_vote;
  } item_t;

  item_t pend[$];

  sortvote_majority #(.K(K), .REG_OUT(1'b1)) uut (
    .clk    (clk),
    .rst    (rst),
    .sums   (sums),
    .sorted (sorted),
    .vote   (vote)
  );

  always #4 clk = ~clk;

  function automatic int ones_of(input logic [K-1:0] v);
    int c = 0;
    for (int i = 0; i < K; i++) c += v[i];
    return c;
  endfunction

  task automatic check(input string req, input logic [K-1:0] act,
                       input logic [K-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic drive(input logic [K-1:0] v);
    item_t it;
    int c;
    c = ones_of(v);
    @(negedge clk);
    sums = v;
    it.vec = v;
    it.exp_sorted = (c == 0) ? '0 : ~((K'(1) << (K - c)) - K'(1));
    it.exp_vote = (2 * c > K);
    pend.push_back(it);
  endtask

  // monitor: each edge consumes the item driven before it
  always @(posedge clk) begin
    #2;
    if (pend.size() > 0) begin
      item_t it;
      int c;
      string vreq;
      it = pend.pop_front();
      c = ones_of(it.vec);
      if (2 * c == K)           vreq = "R2";
      else if (c == 0 || c == K) vreq = "R5";
      else                       vreq = "R1/R7";
      check(vreq, K'(vote), K'(it.exp_vote));
      check("R3", K'(ones_of(sorted)), K'(c));
      check("R4", sorted, it.exp_sorted);
    end
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    sums = 8'hFF;
    repeat (3) @(negedge clk);
    // R6: reset holds outputs at zero despite an all-one input
    check("R6", sorted, '0);
    check("R6", K'(vote), '0);
    rst = 1'b0;

    // R1 R2 R3 R4 R5: every input vector, one per cycle
    for (int v = 0; v < (1 << K); v++) drive(K'(v));

    // R7: alternating extremes, then boundary counts either side of a tie
    for (int r = 0; r < 4; r++) begin
      drive('1);
      drive('0);
    end
    drive(8'b0001_1111);
    drive(8'b1111_0000);
    drive(8'b0000_0111);
    drive(8'b1010_1011);
    drive(8'b0101_0100);
    drive('1);
    @(negedge clk);
    @(negedge clk);

    // R6: reset while a high vote is held
    rst = 1'b1;
    @(negedge clk);
    check("R6", sorted, '0);
    check("R6", K'(vote), '0);
    rst = 1'b0;
    drive(8'b1101_0110);
    @(negedge clk);
    @(negedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule